// File: doc/BRIEF.md
# Request-Triggered SPI Result Responder

This block sits between a host and a capacitance acquisition engine. The host asks for a measurement by pulling an active-low request line low. Once that low level has lasted long enough, the block sends a one-cycle start pulse to the engine. It then waits for the engine's result strobe.

When the result arrives and the request line has already gone high again, the block pulls its active-low ready line low. It puts the most significant result bit on the serial output at once. The host then clocks out 16 bits with its own serial clock, high byte first. The serial output and the ready line are driven only during a transfer; at all other times both enables are low, so several devices can share one bus.

If the request line is still low when the result arrives, the block does not transfer anything. It raises a setup-mode flag and holds it until reset. The result strobe has no ready signal and no back-pressure: the block takes a result only while it waits for one and ignores any strobe at other times.

Top module: `spi_req_responder`

## Requirements
- R1: The acquisition start pulse is issued after `REQ_MIN_CYC` consecutive system-clock samples of the request line at low level. A low pulse one sample shorter issues no start.
- R2: One qualified request gives exactly one single-cycle start pulse, however long the request line is then held low.
- R3: If the synchronized request line is low when the result strobe arrives, the block transfers nothing and raises `setup_mode_o`. The flag stays high until reset.
- R4: A result that arrives while the request line is high raises `drdy_oe_o` with `drdy_n_o` low and raises `sdo_oe_o`. Bit 15 of the result is on `sdo_o` before any serial clock edge.
- R5: The result goes out as 16 bits, bit 15 first and bit 0 last, so the high byte goes first. Any pause between clock edges, including a long gap between the two bytes, is tolerated.
- R6: With `clk_idle_high_i` = 0 the serial clock idles low, and `sdo_o` advances only after a rising edge. With `clk_idle_high_i` = 1 it idles high, and `sdo_o` advances only after a falling edge. The first leading edge keeps bit 15, and each later leading edge presents the next lower bit.
- R7: The ready line stays asserted until the trailing clock edge that follows the 16th leading edge. Both enables then drop within 4 system-clock cycles.
- R8: Outside a transfer, including after reset, `sdo_oe_o` and `drdy_oe_o` are low.
- R9: A request that falls during a transfer is ignored, even if it is still held low after the ready line is released. A new request is accepted only after the line has been seen high while the block is idle.
- R10: A result strobe that arrives while no acquisition is pending is ignored. No transfer starts and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | Active-low measurement request from host (asynchronous) |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| clk_idle_high_i | input | 1 | Serial clock idle level: 0 low, 1 high (static) |
| acq_start_o | output | 1 | Single-cycle start pulse to the acquisition engine |
| acq_valid_i | input | 1 | Result strobe from the acquisition engine |
| acq_data_i | input | 16 | Result word, sampled with the strobe |
| sdo_o | output | 1 | Serial data toward the host |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o` |
| drdy_n_o | output | 1 | Active-low ready level, valid while enabled |
| drdy_oe_o | output | 1 | Drive enable for the ready line |
| setup_mode_o | output | 1 | High after a request was held through the end of acquisition |

## Verification
The bench builds the block with `REQ_MIN_CYC` = 12, so the qualification threshold can be hit exactly and missed by one sample in a short run. The synchronizers stay at two stages and the word stays at 16 bits. With these values the bench sweeps walking-one and walking-zero words, plus all-zero, all-one and alternating words, through both clock polarities, with and without a long gap between the bytes. Within the same run it also reaches the setup-mode diversion, a request held low across a transfer, and a stray result strobe.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_SEND  = 2'd2,
    ST_SETUP = 2'd3
  } srr_state_e;
endpackage

// File: rtl/srr_sync.sv
module srr_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srr_req_qual.sv
module srr_req_qual #(
  parameter int MIN_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic req_low_i,
  output logic fire_o
);
  localparam int CW = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      armed   <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (!en_i) begin
        low_cnt <= '0;
        armed   <= 1'b0;
      end else if (!req_low_i) begin
        low_cnt <= '0;
        armed   <= 1'b1;
      end else if (armed) begin
        if (low_cnt == LAST) begin
          fire_o  <= 1'b1;
          armed   <= 1'b0;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_cnt + 1'b1;
        end
      end
    end
  end

  // R2
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  // R1
  fire_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(req_low_i) && $past(en_i));
endmodule

// File: rtl/srr_sck_edge.sv
module srr_sck_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic idle_high_i,
  output logic lead_o,
  output logic trail_o
);
  logic sck_s;
  logic sck_prev;
  logic rise;
  logic fall;

  srr_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sck_i),
    .q_o   (sck_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign rise    = sck_s & ~sck_prev;
  assign fall    = ~sck_s & sck_prev;
  assign lead_o  = idle_high_i ? fall : rise;
  assign trail_o = idle_high_i ? rise : fall;
endmodule

// File: rtl/srr_shifter.sv
module srr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         active_i,
  input  logic         lead_i,
  input  logic         trail_i,
  output logic         sdo_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] lead_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      lead_cnt <= '0;
    end else if (load_i) begin
      shreg    <= data_i;
      lead_cnt <= '0;
    end else if (active_i && lead_i) begin
      if (lead_cnt != '0)   shreg    <= {shreg[W-2:0], 1'b0};
      if (lead_cnt != FULL) lead_cnt <= lead_cnt + 1'b1;
    end
  end

  assign sdo_o  = shreg[W-1];
  assign done_o = active_i & trail_i & (lead_cnt == FULL);

  // R6
  sdo_moves_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i) && !$past(lead_i) && !$past(load_i)) |-> $stable(sdo_o));
endmodule

// File: rtl/spi_req_responder.sv
module spi_req_responder #(
  parameter int W           = 16,
  parameter int REQ_MIN_CYC = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_n_i,
  input  logic         sck_i,
  input  logic         clk_idle_high_i,
  output logic         acq_start_o,
  input  logic         acq_valid_i,
  input  logic [W-1:0] acq_data_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         drdy_n_o,
  output logic         drdy_oe_o,
  output logic         setup_mode_o
);
  import srr_pkg::*;

  srr_state_e state;
  logic req_s;
  logic req_low;
  logic fire;
  logic lead;
  logic trail;
  logic sh_sdo;
  logic sh_done;
  logic sending;
  logic load;

  srr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_n_i),
    .q_o   (req_s)
  );
  assign req_low = ~req_s;

  srr_req_qual #(.MIN_CYC(REQ_MIN_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (state == ST_IDLE),
    .req_low_i (req_low),
    .fire_o    (fire)
  );

  srr_sck_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_i       (sck_i),
    .idle_high_i (clk_idle_high_i),
    .lead_o      (lead),
    .trail_o     (trail)
  );

  assign sending = (state == ST_SEND);
  assign load    = (state == ST_ACQ) & acq_valid_i & ~req_low;

  srr_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .data_i   (acq_data_i),
    .active_i (sending),
    .lead_i   (lead),
    .trail_i  (trail),
    .sdo_o    (sh_sdo),
    .done_o   (sh_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (fire) state <= ST_ACQ;
        ST_ACQ:   if (acq_valid_i) state <= req_low ? ST_SETUP : ST_SEND;
        ST_SEND:  if (sh_done) state <= ST_IDLE;
        default:  state <= ST_SETUP;
      endcase
    end
  end

  assign acq_start_o  = fire;
  assign sdo_oe_o     = sending;
  assign sdo_o        = sending ? sh_sdo : 1'b0;
  assign drdy_oe_o    = sending;
  assign drdy_n_o     = ~sending;
  assign setup_mode_o = (state == ST_SETUP);

  // R1
  start_enters_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start_o |=> (state == ST_ACQ));

  // R3
  setup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_mode_o |=> setup_mode_o);

  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> (sdo_o == $past(acq_data_i[W-1])));

  // R7
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_oe_o) |-> $past(sh_done));

  // R8
  no_drive_in_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_mode_o |-> !sdo_oe_o && !drdy_oe_o);
endmodule

// File: tb/sim_spi_req_responder.sv
module sim_spi_req_responder;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int MINC = 12;
  localparam int HP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic sck = 1'b0;
  logic idle_high = 1'b0;
  logic acq_valid = 1'b0;
  logic [W-1:0] acq_data = '0;
  logic acq_start, sdo, sdo_oe, drdy_n, drdy_oe, setup_mode;

  int total = 0;
  int bad = 0;
  int starts = 0;

  spi_req_responder #(.W(W), .REQ_MIN_CYC(MINC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .sck_i(sck),
    .clk_idle_high_i(idle_high), .acq_start_o(acq_start),
    .acq_valid_i(acq_valid), .acq_data_i(acq_data),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drdy_n_o(drdy_n),
    .drdy_oe_o(drdy_oe), .setup_mode_o(setup_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (acq_start) starts++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_n = 1'b1; acq_valid = 1'b0; sck = idle_high;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic wait_start(input int s0, output bit got);
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (starts != s0) begin got = 1'b1; break; end
      cyc(1);
    end
  endtask

  task automatic give_result(input logic [W-1:0] d);
    cyc(5);
    acq_data = d; acq_valid = 1'b1;
    cyc(1);
    acq_valid = 1'b0;
  endtask

  task automatic xfer(input logic [W-1:0] d, input int gap);
    cyc(2);
    chk(drdy_oe && !drdy_n && sdo_oe, "R4 ready asserted", {drdy_oe, drdy_n, sdo_oe}, 3'b101);
    chk(sdo == d[W-1], "R4 bit15 before clock", sdo, d[W-1]);
    for (int i = 0; i < W; i++) begin
      if (i == 8) cyc(gap);
      if (i > 0) chk(sdo == d[W-i], "R6 held until leading edge", sdo, d[W-i]);
      sck = ~idle_high;
      cyc(HP);
      chk(sdo == d[W-1-i], "R5 bit order", sdo, d[W-1-i]);
      chk(drdy_oe == 1'b1, "R7 ready held", drdy_oe, 1);
      sck = idle_high;
      cyc(HP);
    end
    chk(!sdo_oe && !drdy_oe, "R7 R8 released", {sdo_oe, drdy_oe}, 0);
  endtask

  task automatic run(input logic [W-1:0] d, input bit mode, input int gap);
    int s0;
    bit got;
    idle_high = mode; sck = mode;
    cyc(4);
    s0 = starts;
    req_n = 1'b0; cyc(MINC); req_n = 1'b1;
    wait_start(s0, got);
    chk(got, "R1 start at threshold", got, 1);
    give_result(d);
    xfer(d, gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    bit got;
    do_reset();
    chk(!sdo_oe && !drdy_oe && !setup_mode && !acq_start, "R8 reset state",
        {sdo_oe, drdy_oe, setup_mode, acq_start}, 0);

    // R1: one sample short
    s0 = starts;
    req_n = 1'b0; cyc(MINC-1); req_n = 1'b1;
    cyc(40);
    chk(starts == s0, "R1 short pulse ignored", starts - s0, 0);

    // R2: long hold gives a single start
    s0 = starts;
    req_n = 1'b0; cyc(3*MINC); req_n = 1'b1;
    cyc(4);
    chk(starts == s0 + 1, "R2 single start", starts - s0, 1);
    give_result(16'hC3A5);
    xfer(16'hC3A5, 0);

    // R10: stray strobe
    acq_data = 16'hFFFF; acq_valid = 1'b1; cyc(1); acq_valid = 1'b0;
    cyc(4);
    chk(!sdo_oe && !drdy_oe && !setup_mode, "R10 stray strobe ignored",
        {sdo_oe, drdy_oe, setup_mode}, 0);

    // sweeps over both clock polarities
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < W; b++) begin
        run(W'(1) << b, m[0], 3);
        run(~(W'(1) << b), m[0], 0);
      end
      run(16'hA55A, m[0], 120);
      run(16'h0000, m[0], 0);
      run(16'hFFFF, m[0], 120);
    end

    // R9: request falls during transfer and is still low after release
    idle_high = 1'b0; sck = 1'b0; cyc(4);
    s0 = starts;
    req_n = 1'b0; cyc(MINC); req_n = 1'b1;
    wait_start(s0, got);
    give_result(16'h5A0F);
    req_n = 1'b0;
    xfer(16'h5A0F, 0);
    s0 = starts;
    cyc(3*MINC);
    chk(starts == s0, "R9 held request ignored", starts - s0, 0);
    req_n = 1'b1; cyc(4);
    req_n = 1'b0; cyc(MINC); req_n = 1'b1;
    wait_start(s0, got);
    chk(got, "R9 rearmed after high", got, 1);
    give_result(16'h0F5A);
    xfer(16'h0F5A, 0);

    // R3: request held through the result
    s0 = starts;
    req_n = 1'b0; cyc(MINC + 10);
    chk(starts == s0 + 1, "R3 start while held", starts - s0, 1);
    give_result(16'h1234);
    cyc(3);
    chk(setup_mode == 1'b1, "R3 setup flag", setup_mode, 1);
    chk(!sdo_oe && !drdy_oe, "R3 no transfer", {sdo_oe, drdy_oe}, 0);
    req_n = 1'b1;
    for (int k = 0; k < 4; k++) begin sck = ~sck; cyc(HP); end
    cyc(30);
    chk(setup_mode == 1'b1, "R3 flag sticky", setup_mode, 1);
    chk(!sdo_oe && !drdy_oe, "R8 idle in setup", {sdo_oe, drdy_oe}, 0);
    do_reset();
    chk(setup_mode == 1'b0, "R3 cleared by reset", setup_mode, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule